// File: doc/BRIEF.md
# Four-Mode Mantissa Rounding Unit

This block rounds a fixed-width unsigned mantissa that carries two extra low-order bits, guard above round, plus a separate sticky bit collected from everything shifted out earlier. It discards the guard and round bits by shifting the mantissa right two places. It then adds one in the least significant position when the chosen rounding direction calls for it. The increment ripples across the whole kept width, and the carry-out is kept as an extra top bit of the result.

A result that lands on the next power of two is handed out as it is. The consumer renormalises it and adjusts the exponent. Alongside the mantissa the block reports whether the value was incremented, whether any precision was lost, and a separate fraction-rounded flag. The decision logic is combinational, and the result is registered once: it appears with a valid strobe one clock after the input strobe. The sign input only steers the two directed modes.

Top module: `mant_round_unit`

## Requirements
- R1: The result mantissa is (MANT_W-1) bits wide and equals the input shifted right by two, plus one when an increment occurs; input bit 1 is guard and input bit 0 is round.
- R2: When guard, round and sticky are all zero, the result is the truncated input, and the rounded-up, inexact and fraction-rounded flags are all clear.
- R3: The inexact flag is set whenever guard, round or sticky is one, in every mode.
- R4: Mode 2'b00 rounds to nearest with ties to even. It never increments with guard zero. With guard one, it increments when round is one, sticky is one, or bit 0 of the truncated value is one.
- R5: Mode 2'b01 (toward zero) never increments.
- R6: Mode 2'b10 (toward plus infinity) increments exactly when the value is inexact and the sign is 0. Mode 2'b11 (toward minus infinity) increments exactly when the value is inexact and the sign is 1.
- R7: The rounded-up flag and the fraction-rounded flag are both set when an increment occurs, and both are clear otherwise.
- R8: The increment carries through every kept bit. A truncated value of all ones plus an increment gives a 1 in the top result bit and zeros below it, with no renormalisation.
- R9: Results and out_valid appear on the clock edge after the one that samples in_valid high. With in_valid low, out_valid is low and the other outputs keep their last values.
- R10: While reset is held, and until the first valid input, out_valid and all result outputs are zero. Reset is asynchronous, active-low, and is released through a two-stage synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe; captures a rounding request |
| in_mant | input | MANT_W | Mantissa; bit 1 guard, bit 0 round |
| in_sticky | input | 1 | OR of all bits shifted out below round |
| in_sign | input | 1 | Sign of the value, 1 = negative |
| in_mode | input | 2 | Rounding direction: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_mant | output | MANT_W-1 | Rounded mantissa including carry-out bit |
| out_up | output | 1 | Increment was applied |
| out_inexact | output | 1 | Precision was lost |
| out_frac_rounded | output | 1 | Fraction was rounded upward |

## Verification
The bench builds the unit with MANT_W set to 10. That leaves an 8-bit truncated field, so a random stream reaches the all-ones carry into the top result bit often, alongside every guard, round and sticky combination in all four modes. Directed cases pin the tie-to-even split on the truncated LSB, the sign steering of the directed modes, and the hold behaviour with in_valid low. A behavioural integer model predicts each cycle's outputs, which are compared every clock.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_PINF = 2'b10,
    RM_MINF = 2'b11
  } rmode_e;
endpackage

// File: rtl/rnd_rst_sync.sv
module rnd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/rnd_decide.sv
module rnd_decide
  import rnd_pkg::*;
(
  input  logic   lsb,
  input  logic   guard,
  input  logic   rbit,
  input  logic   sticky,
  input  logic   sign,
  input  rmode_e mode,
  output logic   inc,
  output logic   inexact
);
  always_comb begin
    inexact = guard | rbit | sticky;
    unique case (mode)
      RM_ZERO: inc = 1'b0;
      RM_PINF: inc = inexact & ~sign;
      RM_MINF: inc = inexact & sign;
      default: inc = guard & (rbit | sticky | lsb);
    endcase
  end
endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
  parameter int W = 30
) (
  input  logic [W-1:0] a,
  input  logic         inc,
  output logic [W:0]   sum
);
  logic [W:0] carry;

  assign carry[0] = inc;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]     = a[i] ^ carry[i];
    assign carry[i+1] = a[i] & carry[i];
  end

  assign sum[W] = carry[W];
endmodule

// File: rtl/mant_round_unit.sv
module mant_round_unit
  import rnd_pkg::*;
#(
  parameter int MANT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [MANT_W-1:0] in_mant,
  input  logic              in_sticky,
  input  logic              in_sign,
  input  logic [1:0]        in_mode,
  output logic              out_valid,
  output logic [MANT_W-2:0] out_mant,
  output logic              out_up,
  output logic              out_inexact,
  output logic              out_frac_rounded
);
  localparam int KEEP_W = MANT_W - 2;
  localparam int RES_W  = KEEP_W + 1;

  logic              rst_sync_n;
  logic [KEEP_W-1:0] trunc;
  logic              do_inc;
  logic              lost;
  logic [RES_W-1:0]  sum;

  logic              valid_q, valid_d;
  logic [RES_W-1:0]  mant_q, mant_d;
  logic              up_q, up_d;
  logic              inx_q, inx_d;

  rnd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign trunc = in_mant[MANT_W-1:2];

  rnd_decide u_dec (
    .lsb     (trunc[0]),
    .guard   (in_mant[1]),
    .rbit    (in_mant[0]),
    .sticky  (in_sticky),
    .sign    (in_sign),
    .mode    (rmode_e'(in_mode)),
    .inc     (do_inc),
    .inexact (lost)
  );

  rnd_incr #(.W(KEEP_W)) u_inc (
    .a   (trunc),
    .inc (do_inc),
    .sum (sum)
  );

  always_comb begin
    valid_d = in_valid;
    mant_d  = mant_q;
    up_d    = up_q;
    inx_d   = inx_q;
    if (in_valid) begin
      mant_d = sum;
      up_d   = do_inc;
      inx_d  = lost;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= 1'b0;
      mant_q  <= '0;
      up_q    <= 1'b0;
      inx_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      mant_q  <= mant_d;
      up_q    <= up_d;
      inx_q   <= inx_d;
    end
  end

  assign out_valid        = valid_q;
  assign out_mant         = mant_q;
  assign out_up           = up_q;
  assign out_inexact      = inx_q;
  assign out_frac_rounded = up_q;
endmodule

// File: rtl/mant_round_chk.sv
module mant_round_chk #(
  parameter int MANT_W = 32
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              in_valid,
  input logic [MANT_W-1:0] in_mant,
  input logic              in_sticky,
  input logic              in_sign,
  input logic [1:0]        in_mode,
  input logic              out_valid,
  input logic [MANT_W-2:0] out_mant,
  input logic              out_up,
  input logic              out_inexact,
  input logic              out_frac_rounded
);
  localparam int RES_W = MANT_W - 1;

  AST_VALUE_TRACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_mant == RES_W'($past(in_mant) >> 2) + RES_W'(out_up)); // R1
  AST_EXACT_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_mant[1:0] == 2'b00 && !in_sticky) |=> (!out_up && !out_inexact)); // R2
  AST_LOSS_FLAG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && (in_mant[1:0] != 2'b00 || in_sticky)) |=> out_inexact); // R3
  AST_NEAR_NO_GUARD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_mode == 2'b00 && !in_mant[1]) |=> !out_up); // R4
  AST_ZERO_NEVER: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_mode == 2'b01) |=> !out_up); // R5
  AST_PINF_NEG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_mode == 2'b10 && in_sign) |=> !out_up); // R6
  AST_MINF_POS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && in_mode == 2'b11 && !in_sign) |=> !out_up); // R6
  AST_FLAG_PAIR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_up == out_frac_rounded); // R7
  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> (!out_valid && $stable(out_mant) && $stable(out_up) && $stable(out_inexact))); // R9
endmodule

bind mant_round_unit mant_round_chk #(.MANT_W(MANT_W)) u_chk (
  .clk              (clk),
  .rst_sync_n       (rst_sync_n),
  .in_valid         (in_valid),
  .in_mant          (in_mant),
  .in_sticky        (in_sticky),
  .in_sign          (in_sign),
  .in_mode          (in_mode),
  .out_valid        (out_valid),
  .out_mant         (out_mant),
  .out_up           (out_up),
  .out_inexact      (out_inexact),
  .out_frac_rounded (out_frac_rounded)
);

// File: tb/sim_mant_round_unit.sv
`timescale 1ns/1ps
module sim_mant_round_unit;
  localparam int MW = 10;
  localparam int RW = MW - 1;

  logic          clk;
  logic          rst_n;
  logic          in_valid;
  logic [MW-1:0] in_mant;
  logic          in_sticky;
  logic          in_sign;
  logic [1:0]    in_mode;
  logic          out_valid;
  logic [RW-1:0] out_mant;
  logic          out_up;
  logic          out_inexact;
  logic          out_frac_rounded;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int e_valid = 0, e_mant = 0, e_up = 0, e_inx = 0;

  mant_round_unit #(.MANT_W(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mant(in_mant),
    .in_sticky(in_sticky), .in_sign(in_sign), .in_mode(in_mode),
    .out_valid(out_valid), .out_mant(out_mant), .out_up(out_up),
    .out_inexact(out_inexact), .out_frac_rounded(out_frac_rounded)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic compare(input string tag);
    int got;
    got = {out_valid, out_up, out_frac_rounded, out_inexact};
    checks++;
    if (out_valid !== e_valid[0] || out_mant !== e_mant[RW-1:0] || out_up !== e_up[0]
        || out_frac_rounded !== e_up[0] || out_inexact !== e_inx[0]) begin
      errors++;
      $display("FAIL %s: got v=%0d mant=%0h up=%0d fr=%0d inx=%0d exp v=%0d mant=%0h up=%0d fr=%0d inx=%0d",
               tag, out_valid, out_mant, out_up, out_frac_rounded, out_inexact,
               e_valid, e_mant, e_up, e_up, e_inx);
    end
  endtask

  // Drive at a falling edge, predict, then check at the next falling edge.
  task automatic step(input bit v, input int m, input bit s, input bit sg,
                      input int md, input string tag);
    int tr, g, r, lost, inc;
    in_valid = v; in_mant = m[MW-1:0]; in_sticky = s; in_sign = sg; in_mode = md[1:0];
    e_valid = v;
    if (v) begin
      tr   = (m % (1 << MW)) / 4;
      g    = (m / 2) % 2;
      r    = m % 2;
      lost = (g != 0 || r != 0 || s) ? 1 : 0;
      if (md == 1)      inc = 0;
      else if (md == 2) inc = (lost == 1 && !sg) ? 1 : 0;
      else if (md == 3) inc = (lost == 1 && sg) ? 1 : 0;
      else              inc = (g == 1 && (r == 1 || s || (tr % 2) == 1)) ? 1 : 0;
      e_mant = tr + inc;
      e_up   = inc;
      e_inx  = lost;
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; in_mant = '1; in_sticky = 1; in_sign = 1; in_mode = 2'b10;
    repeat (3) @(negedge clk);
    compare("R10 reset");
    rst_n = 1;
    repeat (3) @(negedge clk);
    compare("R10 after release");

    step(1, 'h1A4, 0, 0, 0, "R2 exact");
    step(1, 'h1A4, 0, 1, 3, "R2 exact minus");
    step(1, 'h0A2, 0, 0, 0, "R4 tie even stays");
    step(1, 'h0A6, 0, 0, 0, "R4 tie odd bumps");
    step(1, 'h0A1, 0, 0, 0, "R4 no guard");
    step(1, 'h0A2, 1, 0, 0, "R4 sticky bumps");
    step(1, 'h0A0, 1, 0, 0, "R3 sticky only");
    step(1, 'h3FF, 0, 0, 0, "R8 carry to top");
    step(1, 'h3FF, 1, 0, 1, "R5 zero mode");
    step(1, 'h0A1, 0, 0, 2, "R6 plus positive");
    step(1, 'h0A1, 0, 1, 2, "R6 plus negative");
    step(1, 'h0A1, 0, 1, 3, "R6 minus negative");
    step(1, 'h0A1, 0, 0, 3, "R6 minus positive");
    step(1, 'h3FD, 0, 1, 3, "R8 carry minus");
    step(0, 'h155, 1, 0, 2, "R9 hold");
    step(0, 'h000, 0, 1, 0, "R9 hold again");
    step(1, 'h102, 0, 0, 0, "R1 shift");

    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 8) != 0, $urandom % (1 << MW), $urandom % 2,
           $urandom % 2, $urandom % 4, "R7 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule